// File: doc/BRIEF.md
# Serial Converter Command and Readout Interface

This block is the digital slave side of a multichannel successive-approximation converter that runs its conversion from an internal clock. The host lowers chip-select, clocks in a command byte on rising SCLK edges, and keeps clocking until the sixteenth rising edge. At that point timing passes to an internal clock. After a short wake delay the internal clock runs an acquisition window and then resolves one result bit per internal cycle. An end-of-conversion flag is high for the whole conversion. Its falling edge tells the host that the result is ready and that SCLK may run again. The result is then read out MSB first on DOUT in a 16-bit frame.

A synthesizable stub stands in for the analog front end. When the handoff happens, the stub computes a per-channel value and then delivers it one bit per resolving internal cycle. The internal clock is a synchronous enable derived from the system clock.

The inputs cs_n, sclk and din are taken to be synchronous to clk and to be slower than it. The serial pins carry no valid/ready handshake and have no back-pressure. The host paces every transfer through SCLK, and the block never stalls it. The only flow-control signal is the end-of-conversion flag, and the host must wait for it before reading.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset, dout_oe, eoc, acq and dout are all low.
- R2: After cs_n falls, dout_oe goes high within two clk cycles. From then until eoc falls, dout stays low, and this includes the whole time eoc is high.
- R3: DIN is sampled on rising SCLK edges 1 to 8 into cmd_byte, MSB first. The channel field is the first three bits shifted in. It appears on sel_chan right after the 3rd rising edge, and sel_chan changes on no other event.
- R4: A conversion starts only on the 16th rising SCLK edge. eoc is then high for exactly WAKE_DLY + 32*ICLK_DIV clk cycles. That is the wake delay followed by 32 internal clock cycles.
- R5: acq is high only while eoc is high. It is high from the 2nd rising internal clock edge until the 19th, which makes 17*ICLK_DIV clk cycles.
- R6: The result is RES_BASE + channel*RES_STEP modulo 2^14. It is left-justified in a 16-bit frame whose two trailing bits are zero. The frame MSB is on dout as soon as eoc falls, and each falling SCLK edge moves to the next bit.
- R7: SCLK cycles beyond the 16th, before cs_n rises, shift the same frame out again from its MSB.
- R8: Raising cs_n while eoc is high aborts the conversion. eoc and dout_oe are low one cycle later, and a later command converts normally.
- R9: SCLK edges while eoc is high have no effect. The eoc duration and the result are unchanged.
- R10: Raising cs_n before the 16th rising SCLK edge starts no conversion, so eoc stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the internal clock is an enable derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Host serial clock |
| din | input | 1 | Serial command input, sampled on rising SCLK |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for dout (high impedance when low) |
| eoc | output | 1 | High while a conversion runs; its falling edge marks the result as ready |
| acq | output | 1 | High during the acquisition window |
| sel_chan | output | CH_W | Channel currently selected |
| cmd_byte | output | CMD_W | Last command byte captured |

## Verification
Some rules are checked on every cycle. dout stays low while a command is loading. acq is never high without eoc. sel_chan moves only on a qualifying SCLK edge. A conversion starts only after a rising SCLK edge. A chip-select rise clears eoc and dout_oe on the next cycle. The stored result holds still during readout. Other behaviour only the directed scenarios can show: the exact eoc and acq durations, the per-channel result values, the frame layout and its repetition, the edges ignored during conversion, and recovery after both kinds of abort.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    PH_OFF,
    PH_CMD,
    PH_WAKE,
    PH_RUN,
    PH_READ
  } phase_t;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign cs_fall   = ~cs_n & cs_q;
  assign cs_rise   = cs_n & ~cs_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int CMD_W     = 8,
  parameter int HANDOFF   = 16,
  parameter int WAKE_DLY  = 3,
  parameter int ICLK_DIV  = 4,
  parameter int ACQ_FIRST = 2,
  parameter int ACQ_LAST  = 18,
  parameter int RES_W     = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic            sclk_rise,
  input  logic            cs_fall,
  input  logic            cs_rise,
  output phase_t          phase,
  output logic [CH_W-1:0] chan,
  output logic [CMD_W-1:0] cmd,
  output logic            conv_load,
  output logic            conv_step,
  output logic            eoc,
  output logic            acq
);
  localparam int TOTAL = ACQ_LAST + RES_W;
  localparam int TW    = $clog2(TOTAL + 1);
  localparam int EW    = $clog2(HANDOFF);
  localparam int WW    = $clog2(WAKE_DLY + 1);
  localparam int DW    = $clog2(ICLK_DIV + 1);

  localparam logic [EW-1:0] E_LAST   = EW'(HANDOFF - 1);
  localparam logic [EW-1:0] E_CHAN   = EW'(CH_W - 1);
  localparam logic [EW-1:0] E_CMD    = EW'(CMD_W);
  localparam logic [WW-1:0] W_LAST   = WW'(WAKE_DLY - 1);
  localparam logic [DW-1:0] D_LAST   = DW'(ICLK_DIV - 1);
  localparam logic [TW-1:0] T_LAST   = TW'(TOTAL - 1);
  localparam logic [TW-1:0] T_AFIRST = TW'(ACQ_FIRST);
  localparam logic [TW-1:0] T_ALAST  = TW'(ACQ_LAST);

  logic [EW-1:0] edge_cnt;
  logic [WW-1:0] wake_cnt;
  logic [DW-1:0] div_cnt;
  logic [TW-1:0] tick;
  logic          iclk_en;

  assign iclk_en = (phase == PH_RUN) && (div_cnt == D_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      edge_cnt <= '0;
      cmd      <= '0;
      chan     <= '0;
      wake_cnt <= '0;
      div_cnt  <= '0;
      tick     <= '0;
    end else if (cs_rise) begin
      phase <= PH_OFF;
    end else begin
      unique case (phase)
        PH_OFF: begin
          if (cs_fall) begin
            phase    <= PH_CMD;
            edge_cnt <= '0;
            cmd      <= '0;
          end
        end
        PH_CMD: begin
          if (sclk_rise) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt < E_CMD) cmd <= {cmd[CMD_W-2:0], din};
            if (edge_cnt == E_CHAN) chan <= {cmd[CH_W-2:0], din};
            if (edge_cnt == E_LAST) begin
              phase    <= PH_WAKE;
              wake_cnt <= '0;
            end
          end
        end
        PH_WAKE: begin
          wake_cnt <= wake_cnt + 1'b1;
          if (wake_cnt == W_LAST) begin
            phase   <= PH_RUN;
            div_cnt <= '0;
            tick    <= '0;
          end
        end
        PH_RUN: begin
          if (iclk_en) begin
            div_cnt <= '0;
            tick    <= tick + 1'b1;
            if (tick == T_LAST) phase <= PH_READ;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign conv_load = (phase == PH_CMD) && sclk_rise && (edge_cnt == E_LAST) && !cs_rise;
  assign conv_step = iclk_en && (tick >= T_ALAST) && !cs_rise;
  assign eoc       = (phase == PH_WAKE) || (phase == PH_RUN);
  assign acq       = (phase == PH_RUN) && (tick >= T_AFIRST) && (tick <= T_ALAST);

  // R5
  acq_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> eoc);

  // R4
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(sclk_rise));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == PH_CMD && sclk_rise) |=> $stable(chan));
endmodule

// File: rtl/sadc_sar_stub.sv
module sadc_sar_stub #(
  parameter int                CH_W     = 3,
  parameter int                RES_W    = 14,
  parameter logic [RES_W-1:0]  RES_BASE = 14'h2A5C,
  parameter logic [RES_W-1:0]  RES_STEP = 14'h0731
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] chan,
  input  logic            load,
  input  logic            step,
  output logic            bit_o
);
  logic [RES_W-1:0] shreg;
  logic [RES_W-1:0] seed;

  assign seed = RES_BASE + RES_W'(chan) * RES_STEP;

  always_ff @(posedge clk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= seed;
    else if (step) shreg <= {shreg[RES_W-2:0], 1'b0};
  end

  assign bit_o = shreg[RES_W-1];
endmodule

// File: rtl/sadc_readout.sv
module sadc_readout #(
  parameter int RES_W   = 14,
  parameter int FRAME_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic bit_i,
  input  logic in_read,
  input  logic sclk_fall,
  output logic dout
);
  localparam int IW = $clog2(FRAME_W);
  localparam logic [IW-1:0] I_LAST = IW'(FRAME_W - 1);

  logic [RES_W-1:0]   res;
  logic [IW-1:0]      idx;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
      idx <= '0;
    end else if (load) begin
      res <= '0;
      idx <= '0;
    end else begin
      if (step) res <= {res[RES_W-2:0], bit_i};
      if (in_read && sclk_fall) idx <= (idx == I_LAST) ? '0 : idx + 1'b1;
    end
  end

  assign frame = {res, {(FRAME_W - RES_W){1'b0}}};
  assign dout  = in_read ? frame[I_LAST - idx] : 1'b0;

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && $past(in_read)) |-> $stable(res));
endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
  import sadc_pkg::*;
#(
  parameter int               CH_W      = 3,
  parameter int               CMD_W     = 8,
  parameter int               RES_W     = 14,
  parameter int               FRAME_W   = 16,
  parameter int               WAKE_DLY  = 3,
  parameter int               ICLK_DIV  = 4,
  parameter logic [RES_W-1:0] RES_BASE  = 14'h2A5C,
  parameter logic [RES_W-1:0] RES_STEP  = 14'h0731
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic             eoc,
  output logic             acq,
  output logic [CH_W-1:0]  sel_chan,
  output logic [CMD_W-1:0] cmd_byte
);
  logic   sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic   conv_load, conv_step, stub_bit;
  phase_t phase;

  sadc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  sadc_seq #(
    .CH_W(CH_W), .CMD_W(CMD_W), .HANDOFF(FRAME_W), .WAKE_DLY(WAKE_DLY),
    .ICLK_DIV(ICLK_DIV), .ACQ_FIRST(2), .ACQ_LAST(18), .RES_W(RES_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .din(din), .sclk_rise(sclk_rise),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .phase(phase), .chan(sel_chan),
    .cmd(cmd_byte), .conv_load(conv_load), .conv_step(conv_step),
    .eoc(eoc), .acq(acq)
  );

  sadc_sar_stub #(
    .CH_W(CH_W), .RES_W(RES_W), .RES_BASE(RES_BASE), .RES_STEP(RES_STEP)
  ) u_stub (
    .clk(clk), .rst_n(rst_n), .chan(sel_chan), .load(conv_load),
    .step(conv_step), .bit_o(stub_bit)
  );

  sadc_readout #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_read (
    .clk(clk), .rst_n(rst_n), .load(conv_load), .step(conv_step),
    .bit_i(stub_bit), .in_read(phase == PH_READ), .sclk_fall(sclk_fall),
    .dout(dout)
  );

  assign dout_oe = (phase != PH_OFF);

  // R2
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD || eoc) |-> (dout_oe && !dout));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (!eoc && !dout_oe));
endmodule

// File: tb/sadc_serial_if_tb.sv
module sadc_serial_if_tb;
  localparam int WAKE_DLY = 3;
  localparam int ICLK_DIV = 4;
  localparam logic [13:0] BASE = 14'h2A5C;
  localparam logic [13:0] STEP = 14'h0731;
  localparam int EOC_CYC = WAKE_DLY + 32 * ICLK_DIV;
  localparam int ACQ_CYC = 17 * ICLK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic dout, dout_oe, eoc, acq;
  logic [2:0] sel_chan;
  logic [7:0] cmd_byte;

  int n_tests = 0;
  int n_fail = 0;
  int eoc_cnt = 0;
  int acq_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sadc_serial_if #(
    .WAKE_DLY(WAKE_DLY), .ICLK_DIV(ICLK_DIV), .RES_BASE(BASE), .RES_STEP(STEP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .eoc(eoc), .acq(acq),
    .sel_chan(sel_chan), .cmd_byte(cmd_byte)
  );

  always @(negedge clk) begin
    if (eoc) eoc_cnt <= eoc_cnt + 1;
    if (acq) acq_cnt <= acq_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input int ch);
    logic [13:0] r;
    r = BASE + 14'(ch) * STEP;
    return {r, 2'b00};
  endfunction

  task automatic pulse(input logic d);
    @(negedge clk);
    din  = d;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(posedge clk);
    eoc_cnt = 0;
    acq_cnt = 0;
  endtask

  task automatic send_cmd(input logic [7:0] b, input bit chk);
    for (int i = 0; i < 16; i++) begin
      pulse(i < 8 ? b[7-i] : 1'b0);
      if (chk && i == 2) check(sel_chan == b[7:5], "R3 chan after 3rd edge", sel_chan, b[7:5]);
      if (chk && i == 4) check(dout == 1'b0 && dout_oe, "R2 dout low in command", dout, 0);
    end
    if (chk) check(cmd_byte == b, "R3 command byte", cmd_byte, b);
  endtask

  task automatic wait_eoc_low();
    int n = 0;
    while (eoc && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic read_frame(output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      w[15-i] = dout;
      pulse(1'b0);
    end
  endtask

  task automatic t_reset();
    check(!dout_oe && !eoc && !acq && !dout, "R1 reset outputs",
          {dout_oe, eoc, acq, dout}, 0);
  endtask

  task automatic t_convert(input int ch, input bit busy_clk, input bit repeat_rd);
    logic [7:0]  b;
    logic [15:0] w, w2, e;
    b = {3'(ch), 5'b10110};
    e = exp_frame(ch);
    clear_counts();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dout_oe && !dout, "R2 oe after cs fall", {dout_oe, dout}, 2);
    send_cmd(b, 1'b1);
    if (busy_clk) begin
      for (int k = 0; k < 3; k++) pulse(1'b1);
    end
    wait_eoc_low();
    check(eoc_cnt == EOC_CYC, busy_clk ? "R9 eoc length with busy SCLK" : "R4 eoc length",
          eoc_cnt, EOC_CYC);
    check(acq_cnt == ACQ_CYC, "R5 acq length", acq_cnt, ACQ_CYC);
    check(dout == e[15], "R6 MSB at eoc fall", dout, e[15]);
    read_frame(w);
    check(w == e, busy_clk ? "R9 result with busy SCLK" : "R6 frame", w, e);
    if (repeat_rd) begin
      read_frame(w2);
      check(w2 == e, "R7 repeated frame", w2, e);
    end
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!dout_oe, "R2 oe off after cs rise", dout_oe, 0);
  endtask

  task automatic t_abort_conv();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    send_cmd(8'b011_00000, 1'b0);
    repeat (20) @(negedge clk);
    check(eoc == 1'b1, "R8 conversion running", eoc, 1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!eoc && !dout_oe, "R8 abort clears eoc/oe", {eoc, dout_oe}, 0);
    repeat (200) @(negedge clk);
    check(!eoc, "R8 stays shut down", eoc, 0);
  endtask

  task automatic t_abort_cmd();
    clear_counts();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) pulse(1'b1);
    cs_n = 1'b1;
    repeat (200) @(negedge clk);
    check(eoc_cnt == 0, "R10 no conversion after short command", eoc_cnt, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert(0, 1'b0, 1'b0);
    t_convert(5, 1'b0, 1'b1);
    t_convert(7, 1'b1, 1'b0);
    t_abort_conv();
    t_convert(2, 1'b0, 1'b0);
    t_abort_cmd();
    t_convert(6, 1'b0, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule